// File: doc/BRIEF.md
# Single-Wire Factory ID Responder

This block is the slave side of an open-drain single-wire bus that carries nothing but a 64-bit identity. The ID is built at elaboration time from two parameters, an 8-bit family code and a 48-bit serial number. An 8-bit CRC is appended to them. The block takes the already-synchronised bus level and a one-microsecond enable pulse. Its only output is a pull-low enable for the pad.

A bus master starts every exchange with a long low pulse. The responder answers with a presence pulse and then collects an 8-bit command through write slots. Two opcodes make it shift out the whole ID. A third opcode makes it join the bit-by-bit search arbitration. Every other opcode, including the addressing commands that it does not need, sends it silent until the next long low. All timing inside a slot is counted in microsecond ticks from the master's falling edge.

Top module: `owid_responder`

## Requirements
- R1: The 64-bit ID places the family code in bits 7:0 and the serial number in bits 55:8. Bits 63:56 hold a CRC taken over bits 0 to 55 in ascending order. The CRC uses the polynomial x^8+x^5+x^4+1 with bit-reflected shifting (constant 8'h8C) and a zero start value.
- R2: Once the line has been low for at least RST_DET_US ticks and then rises, the responder waits 15 to 60 µs and then pulls the line low for 60 to 240 µs as a presence pulse.
- R3: A low lasting RST_DET_US ticks aborts any command, read or search in progress. After the next presence, a new read starts again from bit 0.
- R4: The command byte is received least significant bit first, one write slot per bit. The line is sampled SAMPLE_US ticks after the falling edge: high reads as 1 and low reads as 0, so a 1-15 µs low is a 1 and a 60-120 µs low is a 0.
- R5: Command 8'h33 and command 8'h0F both start a read that sends all 64 ID bits, bit 0 first, one per read slot.
- R6: To send a 0 in a read slot, the responder holds the line low from the master's falling edge for SAMPLE_US ticks and then releases it. To send a 1, it leaves the line alone.
- R7: Command 8'h55, command 8'hCC and any byte other than 8'h33, 8'h0F or 8'hF0 cause no drive at all until the next reset low.
- R8: Command 8'hF0 runs three slots per ID bit, starting at bit 0: the responder sends the bit, then its complement, then samples the master's chosen bit. If the chosen bit matches, it moves on to the next bit.
- R9: During a search, a chosen bit that differs from the responder's own bit makes it silent until the next reset low.
- R10: After the 64th bit of a read or a search, the responder stays silent until the next reset low.
- R11: From power-on reset until the first bus reset, the responder drives nothing, and it ignores any slots that arrive in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Synchronised bus level (1 = released high) |
| pull_low | output | 1 | Pad drive enable: 1 pulls the bus low |

## Verification
Write slots use random low times anywhere in the legal 1 and 0 windows, which tests the single sampling point against both bit values. Both read opcodes are tried to show they are equivalent. The two addressing opcodes and random unknown bytes are tried to show they differ from a read: the responder stays silent in every read slot that follows. A full matching search and a search that deviates at a random bit separate correct participation from dropping out too early or too late. A reset issued in the middle of a read, and slots sent before any bus reset, show how the long-low detector takes priority over the command state.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [3:0] {
    ST_QUIET,
    ST_RST,
    ST_PRES,
    ST_CMD,
    ST_READ,
    ST_SRCH_BIT,
    ST_SRCH_CMP,
    ST_SRCH_DIR
  } owid_state_e;

  localparam logic [7:0] OP_READ_NEW = 8'h33;
  localparam logic [7:0] OP_READ_OLD = 8'h0F;
  localparam logic [7:0] OP_SEARCH   = 8'hF0;

  // Reflected CRC-8 over 56 bits, lowest bit first
  function automatic logic [7:0] owid_crc8(input logic [55:0] data);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ data[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owid_lowmon.sv
module owid_lowmon #(
  parameter int RST_DET_US = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic long_low,
  output logic rst_evt
);
  localparam int             CW  = $clog2(RST_DET_US + 1);
  localparam logic [CW-1:0]  THR = CW'(RST_DET_US);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;
  logic          evt_q, evt_d;

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (line_in) begin
      cnt_d  = '0;
      long_d = 1'b0;
    end else begin
      if (tick && cnt_q != THR) cnt_d = cnt_q + 1'b1;
      if (cnt_q == THR)         long_d = 1'b1;
    end
    evt_d = line_in & long_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
      evt_q  <= evt_d;
    end
  end

  assign long_low = long_q;
  assign rst_evt  = evt_q;

  // R2: a reset event only follows a qualified long low
  a_r2_evt_after_long: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> $past(long_low));

endmodule

// File: rtl/owid_presence.sv
module owid_presence #(
  parameter int WAIT_US = 30,
  parameter int LOW_US  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic drive,
  output logic done
);
  localparam int            MAXV      = (WAIT_US > LOW_US) ? WAIT_US : LOW_US;
  localparam int            CW        = $clog2(MAXV + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_US - 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_US - 1);

  logic          busy_q, busy_d;
  logic          low_q, low_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    low_d  = low_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      low_d  = 1'b0;
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (!low_q) begin
        if (cnt_q == WAIT_LAST) begin
          low_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == LOW_LAST) begin
        busy_d = 1'b0;
        low_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      low_q  <= low_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign drive = low_q;
  assign done  = done_q;

  // R2: the presence low is only ever driven inside an armed sequence
  a_r2_low_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    low_q |-> busy_q);

  // R2: the drive phase begins only after the wait phase
  a_r2_wait_before_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_q) |-> $past(busy_q && !low_q));

endmodule

// File: rtl/owid_slot.sv
module owid_slot #(
  parameter int SAMPLE_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  input  logic arm,
  input  logic tx_bit,
  output logic drive,
  output logic rx_bit,
  output logic done
);
  localparam int            CW   = $clog2(SAMPLE_US + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_US - 1);

  logic          line_q;
  logic          fall;
  logic          active_q, active_d;
  logic          zero_q, zero_d;
  logic          rx_q, rx_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign fall = line_q & ~line_in;

  always_comb begin
    active_d = active_q;
    zero_d   = zero_q;
    rx_d     = rx_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (arm && fall) begin
        active_d = 1'b1;
        zero_d   = ~tx_bit;
        cnt_d    = '0;
      end
    end else if (tick) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        zero_d   = 1'b0;
        rx_d     = line_in;
        done_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b1;
      active_q <= 1'b0;
      zero_q   <= 1'b0;
      rx_q     <= 1'b1;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      line_q   <= line_in;
      active_q <= active_d;
      zero_q   <= zero_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
    end
  end

  assign drive  = active_q & zero_q;
  assign rx_bit = rx_q;
  assign done   = done_q;

  // R6: a data-0 hold starts only on a master falling edge while armed
  a_r6_drive_starts_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(fall && arm));

  // R6: the hold ends before the count passes the sample point
  a_r6_release_by_sample: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (cnt_q <= LAST));

endmodule

// File: rtl/owid_ctrl.sv
module owid_ctrl
  import owid_pkg::*;
#(
  parameter logic [63:0] ROM = 64'h0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_low,
  input  logic rst_evt,
  input  logic pres_done,
  input  logic slot_done,
  input  logic rx_bit,
  output logic pres_start,
  output logic slot_arm,
  output logic tx_bit
);
  owid_state_e state_q, state_d;
  logic [5:0]  idx_q, idx_d;
  logic [7:0]  cmd_q, cmd_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cmd_d      = cmd_q;
    pres_start = 1'b0;
    if (long_low) begin
      state_d = ST_RST;
    end else begin
      case (state_q)
        ST_RST: if (rst_evt) begin
          pres_start = 1'b1;
          state_d    = ST_PRES;
        end
        ST_PRES: if (pres_done) begin
          state_d = ST_CMD;
          idx_d   = '0;
        end
        ST_CMD: if (slot_done) begin
          cmd_d = {rx_bit, cmd_q[7:1]};
          if (idx_q == 6'd7) begin
            idx_d = '0;
            if (cmd_d == OP_READ_NEW || cmd_d == OP_READ_OLD) state_d = ST_READ;
            else if (cmd_d == OP_SEARCH)                      state_d = ST_SRCH_BIT;
            else                                              state_d = ST_QUIET;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_READ: if (slot_done) begin
          if (idx_q == 6'd63) state_d = ST_QUIET;
          else                idx_d   = idx_q + 1'b1;
        end
        ST_SRCH_BIT: if (slot_done) state_d = ST_SRCH_CMP;
        ST_SRCH_CMP: if (slot_done) state_d = ST_SRCH_DIR;
        ST_SRCH_DIR: if (slot_done) begin
          if (rx_bit != ROM[idx_q] || idx_q == 6'd63) begin
            state_d = ST_QUIET;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_SRCH_BIT;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_READ, ST_SRCH_BIT: tx_bit = ROM[idx_q];
      ST_SRCH_CMP:          tx_bit = ~ROM[idx_q];
      default:              tx_bit = 1'b1;
    endcase
    slot_arm = (state_q == ST_CMD) || (state_q == ST_READ) ||
               (state_q == ST_SRCH_BIT) || (state_q == ST_SRCH_CMP) ||
               (state_q == ST_SRCH_DIR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_QUIET;
      idx_q   <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cmd_q   <= cmd_d;
    end
  end

  // R3: a long low always forces the reset state
  a_r3_long_low_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    long_low |=> (state_q == ST_RST));

  // R4: the command phase never counts beyond eight slots
  a_r4_cmd_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD) |-> (idx_q < 6'd8));

  // R8: after sending its bit the responder sends the complement
  a_r8_search_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRCH_BIT && slot_done && !long_low) |=> (state_q == ST_SRCH_CMP));

  // R9 / R10: the silent state is left only through a long low
  a_r9_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUIET && !long_low) |=> (state_q == ST_QUIET));

endmodule

// File: rtl/owid_responder.sv
module owid_responder
  import owid_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h01,
  parameter logic [47:0] SERIAL      = 48'hA5C3_1E7B_9042,
  parameter int          RST_DET_US  = 240,
  parameter int          PD_WAIT_US  = 30,
  parameter int          PD_LOW_US   = 120,
  parameter int          SAMPLE_US   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_in,
  output logic pull_low
);
  localparam logic [55:0] BODY = {SERIAL, FAMILY_CODE};
  localparam logic [63:0] ROM  = {owid_crc8(BODY), BODY};

  logic long_low, rst_evt;
  logic pres_start, pres_drv, pres_done;
  logic slot_arm, tx_bit, slot_drv, rx_bit, slot_done;

  owid_lowmon #(.RST_DET_US(RST_DET_US)) u_lowmon (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .line_in(line_in),
    .long_low(long_low), .rst_evt(rst_evt)
  );

  owid_presence #(.WAIT_US(PD_WAIT_US), .LOW_US(PD_LOW_US)) u_presence (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .start(pres_start),
    .drive(pres_drv), .done(pres_done)
  );

  owid_slot #(.SAMPLE_US(SAMPLE_US)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .line_in(line_in),
    .arm(slot_arm), .tx_bit(tx_bit), .drive(slot_drv),
    .rx_bit(rx_bit), .done(slot_done)
  );

  owid_ctrl #(.ROM(ROM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .long_low(long_low), .rst_evt(rst_evt),
    .pres_done(pres_done), .slot_done(slot_done), .rx_bit(rx_bit),
    .pres_start(pres_start), .slot_arm(slot_arm), .tx_bit(tx_bit)
  );

  assign pull_low = pres_drv | slot_drv;

  // R2: presence and data drive never overlap
  a_r2_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(pres_drv && slot_drv));

endmodule

// File: tb/owid_responder_bench.sv
`timescale 1ns/1ps
module owid_responder_bench;
  localparam logic [7:0]  FAM = 8'h01;
  localparam logic [47:0] SER = 48'hA5C3_1E7B_9042;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic m_low = 1'b0;
  logic pull_low;
  logic line_in;
  int   checks = 0;
  int   errors = 0;
  logic [63:0] exp_rom;

  assign line_in = ~(m_low | pull_low);

  owid_responder #(.FAMILY_CODE(FAM), .SERIAL(SER)) u_owid_responder (
    .clk(clk), .rst_n(rst_n), .us_tick(tick), .line_in(line_in), .pull_low(pull_low)
  );

  always #4 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    logic x;
    for (int i = 0; i < 56; i++) begin
      x = r[0] ^ d[i];
      r = r >> 1;
      r[7] = x; r[3] = r[3] ^ x; r[2] = r[2] ^ x;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic bus_reset();
    int t_fall = -1;
    int t_rise = -1;
    m_low = 1'b1;
    wait_us(500);
    m_low = 1'b0;
    for (int c = 0; c < 960; c++) begin
      @(negedge clk);
      if (t_fall < 0 && !line_in) t_fall = c;
      else if (t_fall >= 0 && t_rise < 0 && line_in) t_rise = c;
    end
    chk(t_fall >= 30 && t_fall <= 120, "R2 presence wait", 64'(t_fall), 64'd60);
    chk(t_rise > t_fall && (t_rise - t_fall) >= 120 && (t_rise - t_fall) <= 480,
        "R2 presence width", 64'(t_rise - t_fall), 64'd240);
  endtask

  task automatic write_bit(input bit b);
    int lo;
    lo = b ? 2 + int'($urandom % 10) : 65 + int'($urandom % 35);
    m_low = 1'b1;
    wait_us(lo);
    m_low = 1'b0;
    wait_us(b ? 80 - lo : 15);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(output bit b);
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    wait_us(11);
    b = line_in;
    wait_us(32);
    chk(line_in == 1'b1, "R6 released after hold", 64'(line_in), 64'd1);
    wait_us(40);
  endtask

  task automatic read_n(input int n, output logic [63:0] v);
    bit b;
    v = '0;
    for (int i = 0; i < n; i++) begin read_bit(b); v[i] = b; end
  endtask

  initial begin
    int guard = 0;
    while (guard < 190000) begin @(posedge clk); guard++; end
    chk(1'b0, "watchdog", 64'(guard), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [7:0]  op;
    bit b, c;
    int bad;
    int k;
    void'($urandom(32'h1F2E3D4C));
    exp_rom = {ref_crc({SER, FAM}), SER, FAM};

    repeat (5) @(negedge clk);
    chk(pull_low == 1'b0, "R11 no drive in reset", 64'(pull_low), 64'd0);
    rst_n = 1'b1;
    wait_us(5);

    // R11: command and reads before any bus reset are ignored
    write_byte(8'h33);
    read_n(8, v);
    chk(v[7:0] == 8'hFF, "R11 silent before first reset", v, 64'hFF);

    // R1 R5 R4: read with the newer opcode
    bus_reset();
    write_byte(8'h33);
    read_n(64, v);
    chk(v == exp_rom, "R1 R5 read 33h", v, exp_rom);
    read_n(4, v);
    chk(v[3:0] == 4'hF, "R10 silent after 64 bits", v, 64'hF);

    // R5: legacy opcode
    bus_reset();
    write_byte(8'h0F);
    read_n(64, v);
    chk(v == exp_rom, "R5 read 0Fh", v, exp_rom);

    // R7: addressing and unknown opcodes
    for (int t = 0; t < 5; t++) begin
      if (t == 0) op = 8'h55;
      else if (t == 1) op = 8'hCC;
      else begin
        do op = 8'($urandom); while (op == 8'h33 || op == 8'h0F || op == 8'hF0);
      end
      bus_reset();
      write_byte(op);
      read_n(8, v);
      chk(v[7:0] == 8'hFF, "R7 silent after opcode", {56'h0, op}, 64'hFF);
    end

    // R3: reset in the middle of a read restarts at bit 0
    bus_reset();
    write_byte(8'h33);
    read_n(10, v);
    bus_reset();
    write_byte(8'h33);
    read_n(16, v);
    chk(v[15:0] == exp_rom[15:0], "R3 restart from bit 0", v, {48'h0, exp_rom[15:0]});

    // R8: full matching search
    bus_reset();
    write_byte(8'hF0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b); read_bit(c);
      if (b != exp_rom[i] || c != ~exp_rom[i]) bad++;
      write_bit(exp_rom[i]);
    end
    chk(bad == 0, "R8 search bit and complement", 64'(bad), 64'd0);
    read_n(4, v);
    chk(v[3:0] == 4'hF, "R10 silent after search", v, 64'hF);

    // R9: deviate at a random position
    k = 3 + int'($urandom % 38);
    bus_reset();
    write_byte(8'hF0);
    bad = 0;
    for (int i = 0; i <= k; i++) begin
      read_bit(b); read_bit(c);
      if (b != exp_rom[i] || c != ~exp_rom[i]) bad++;
      write_bit(i == k ? ~exp_rom[i] : exp_rom[i]);
    end
    chk(bad == 0, "R8 search up to deviation", 64'(bad), 64'd0);
    read_n(8, v);
    chk(v[7:0] == 8'hFF, "R9 silent after mismatch", v, 64'hFF);
    bus_reset();
    write_byte(8'h33);
    read_n(8, v);
    chk(v[7:0] == exp_rom[7:0], "R9 answers after new reset", v, {56'h0, exp_rom[7:0]});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule